// File: doc/BRIEF.md
# Bidirectional Shift Register with Parallel Load

This block is a small register of `WIDTH` bits, four by default, that a single two-bit select steers through one of four operations on every rising clock edge. It can keep its contents, move them one place toward bit 0, move them one place toward the top bit, or take a new word from a parallel data input. Each bit is a flip-flop fed by a four-way multiplexer, and all the multiplexers share the same select.

Each shift direction has its own serial input, which supplies the bit that enters at the vacated end. Each direction also has its own serial output, which is the bit about to leave at the far end. The register contents and both serial outputs come straight from flip-flops. A synchronous, active-high reset clears the register and overrides any select value.

Top module: `bidir_shift_reg`

## Requirements
- R1: With `sel` = 2'b00 (hold), `q` after the clock edge equals `q` before it, whatever `din`, `sin_l` and `sin_r` carry.
- R2: With `sel` = 2'b01 (shift left), each bit `q[i]` takes the old `q[i+1]`, and the top bit `q[WIDTH-1]` takes `sin_l`.
- R3: With `sel` = 2'b10 (shift right), each bit `q[i]` takes the old `q[i-1]`, and bit `q[0]` takes `sin_r`.
- R4: With `sel` = 2'b11 (parallel load), `q` takes `din` at the clock edge.
- R5: When `rst` is high at a rising edge, `q` becomes all zeros whatever the value of `sel`.
- R6: `sout_r` always equals the current top bit `q[WIDTH-1]`, which is the bit that a right shift pushes out.
- R7: `sout_l` always equals the current bit `q[0]`, which is the bit that a left shift pushes out.
- R8: After `WIDTH` consecutive right shifts, `q` holds the last `WIDTH` values seen on `sin_r`, with the most recent value in `q[0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| sel | input | 2 | Operation: 00 hold, 01 shift left, 10 shift right, 11 load |
| din | input | WIDTH | Parallel data word |
| sin_l | input | 1 | Bit entering the top position on a left shift |
| sin_r | input | 1 | Bit entering position 0 on a right shift |
| q | output | WIDTH | Register contents |
| sout_r | output | 1 | Bit leaving on a right shift (q[WIDTH-1]) |
| sout_l | output | 1 | Bit leaving on a left shift (q[0]) |

## Verification
The bench builds the block with the default `WIDTH` of 4. At that width a complete right-shift fill takes only four edges, and each serial output can be checked against a bit that was known one shift earlier. A final loop cycles `sel` through all four codes while varying the data word and both serial inputs. This exercises each operation from many different starting contents, and it includes a reset issued while a shift is selected.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  // Operation encoding; the numeric values are the external select codes.
  typedef enum logic [1:0] {
    OP_HOLD  = 2'b00,
    OP_SHL   = 2'b01,
    OP_SHR   = 2'b10,
    OP_LOAD  = 2'b11
  } bsr_op_e;

endpackage

// File: rtl/bsr_decode.sv
module bsr_decode
  import bsr_pkg::*;
(
  input  logic [1:0] sel,
  output bsr_op_e    op
);

  always_comb begin
    unique case (sel)
      2'b00:   op = OP_HOLD;
      2'b01:   op = OP_SHL;
      2'b10:   op = OP_SHR;
      default: op = OP_LOAD;
    endcase
  end

endmodule

// File: rtl/bsr_stage.sv
module bsr_stage
  import bsr_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  bsr_op_e op,
  input  logic    from_hi,   // source on a left shift
  input  logic    from_lo,   // source on a right shift
  input  logic    par_in,    // source on a load
  output logic    q
);

  logic d_next;

  // Four-way selector in front of the flop.
  always_comb begin
    unique case (op)
      OP_HOLD: d_next = q;
      OP_SHL:  d_next = from_hi;
      OP_SHR:  d_next = from_lo;
      default: d_next = par_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d_next;
  end

endmodule

// File: rtl/bidir_shift_reg.sv
module bidir_shift_reg
  import bsr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       sel,
  input  logic [WIDTH-1:0] din,
  input  logic             sin_l,
  input  logic             sin_r,
  output logic [WIDTH-1:0] q,
  output logic             sout_r,
  output logic             sout_l
);

  localparam int EXT_W = WIDTH + 2;

  bsr_op_e          op;
  logic [EXT_W-1:0] ext;   // {sin_l, q, sin_r}: neighbours of every stage

  bsr_decode u_dec (
    .sel (sel),
    .op  (op)
  );

  assign ext = {sin_l, q, sin_r};

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    bsr_stage u_stage (
      .clk     (clk),
      .rst     (rst),
      .op      (op),
      .from_hi (ext[i+2]),
      .from_lo (ext[i]),
      .par_in  (din[i]),
      .q       (q[i])
    );
  end

  assign sout_r = q[WIDTH-1];
  assign sout_l = q[0];

endmodule

// File: rtl/bidir_shift_reg_chk.sv
module bidir_shift_reg_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       sel,
  input logic [WIDTH-1:0] din,
  input logic             sin_l,
  input logic             sin_r,
  input logic [WIDTH-1:0] q
);

  localparam int TOP = WIDTH - 1;

  // R1
  a_r1_hold: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b00) |=> $stable(q));

  // R2
  a_r2_shift_left: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b01) |=> (q == {$past(sin_l), $past(q[TOP:1])}));

  // R3
  a_r3_shift_right: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b10) |=> (q == {$past(q[TOP-1:0]), $past(sin_r)}));

  // R4
  a_r4_load: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b11) |=> (q == $past(din)));

  // R5: the reset property checks reset itself and so is not disabled by it
  a_r5_clear: assert property (@(posedge clk)
    rst |=> (q == '0));

endmodule

bind bidir_shift_reg bidir_shift_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .sel   (sel),
  .din   (din),
  .sin_l (sin_l),
  .sin_r (sin_r),
  .q     (q)
);

// File: tb/bidir_shift_reg_tb.sv
module bidir_shift_reg_tb;

  localparam int W = 4;

  typedef struct {
    logic [W-1:0] q;
    logic         so_r;
    logic         so_l;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   sel = 2'b00;
  logic [W-1:0] din = '0;
  logic         sin_l = 1'b0;
  logic         sin_r = 1'b0;
  logic [W-1:0] q;
  logic         sout_r, sout_l;

  int   n_vec = 0;
  int   n_bad = 0;
  exp_t sb[$];
  logic [W-1:0] model = '0;

  always #2 clk = ~clk;

  bidir_shift_reg #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .sel(sel), .din(din),
    .sin_l(sin_l), .sin_r(sin_r),
    .q(q), .sout_r(sout_r), .sout_l(sout_l)
  );

  // Driver: sets the inputs for the next edge and pushes the expected result.
  task automatic apply(input logic r, input logic [1:0] s, input logic [W-1:0] d,
                       input logic sl, input logic sr, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; sel = s; din = d; sin_l = sl; sin_r = sr;
    if (r)              model = '0;                        // R5
    else if (s == 2'b01) model = {sl, model[W-1:1]};       // R2
    else if (s == 2'b10) model = {model[W-2:0], sr};       // R3
    else if (s == 2'b11) model = d;                        // R4
    e.q = model; e.so_r = model[W-1]; e.so_l = model[0]; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: one expected item per edge, compared just after the edge.
  always @(posedge clk) begin
    #1;
    if (sb.size() != 0) begin
      exp_t e;
      e = sb.pop_front();
      n_vec++;
      if (q !== e.q || sout_r !== e.so_r || sout_l !== e.so_l) begin
        n_bad++;
        if (q !== e.q)
          $display("FAIL %s: q=%b expected %b", e.tag, q, e.q);
        if (sout_r !== e.so_r)
          $display("FAIL R6 (%s): sout_r=%b expected %b", e.tag, sout_r, e.so_r);
        if (sout_l !== e.so_l)
          $display("FAIL R7 (%s): sout_l=%b expected %b", e.tag, sout_l, e.so_l);
      end
    end
  end

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    apply(1'b1, 2'b11, 4'hF, 1'b1, 1'b1, "R5 reset over load");
    apply(1'b0, 2'b11, 4'b1010, 1'b0, 1'b0, "R4 load 1010");
    apply(1'b0, 2'b00, 4'b0101, 1'b1, 1'b1, "R1 hold");
    apply(1'b0, 2'b00, 4'b1111, 1'b0, 1'b1, "R1 hold");
    apply(1'b0, 2'b00, 4'b0000, 1'b1, 1'b0, "R1 hold");
    apply(1'b0, 2'b10, 4'b0000, 1'b0, 1'b1, "R3 shift right");
    apply(1'b0, 2'b01, 4'b1111, 1'b0, 1'b1, "R2 shift left");
    apply(1'b0, 2'b01, 4'b0000, 1'b1, 1'b0, "R2 shift left in 1");
    // R8: fill by right shifts, then q reflects the last four serial bits
    apply(1'b0, 2'b10, 4'b0000, 1'b0, 1'b1, "R8 fill");
    apply(1'b0, 2'b10, 4'b0000, 1'b0, 1'b1, "R8 fill");
    apply(1'b0, 2'b10, 4'b0000, 1'b1, 1'b0, "R8 fill");
    apply(1'b0, 2'b10, 4'b0000, 1'b0, 1'b1, "R8 fill 1101");
    apply(1'b1, 2'b01, 4'b0000, 1'b1, 1'b1, "R5 reset over shift");
    for (int i = 0; i < W; i++)
      apply(1'b0, 2'b01, 4'b0000, 1'b1, 1'b0, "R2 fill ones");
    apply(1'b0, 2'b10, 4'b0000, 1'b0, 1'b0, "R6 sout_r after shift right");
    apply(1'b0, 2'b01, 4'b0000, 1'b0, 1'b0, "R7 sout_l after shift left");
    for (int i = 0; i < 48; i++)
      apply(i % 11 == 10, 2'(i % 4), 4'((i * 7 + 3) % 16), i[0], i[1],
            "R1..R5 mixed");
    @(negedge clk);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule